// File: doc/BRIEF.md
# Microcode Sequencer with Run Control

This block steps through a 96-word control store whose 40-bit words each hold the control fields of one micro-operation and the address of the word that follows. The store is kept as 48 rows of 80 bits. Address bit 0 picks which 40-bit half of a row is presented, and address bits 6..1 pick the row. When the presented word has its fetch bit set, the next step goes to the start address supplied by the instruction side instead of the address inside the word. This ends the current instruction. The current micro-address sits in one of two alternating address registers. Each step loads the idle register and makes it current.

A run-control unit takes single-cycle console pulses and decides when a step happens. It can run continuously, stop at once, execute a single word, run to the end of the current instruction, or finish the running instruction and then stop. A word with its clock-off bit set stops the machine after it executes. The store rows are filled through a row write port. Downstream logic decodes the presented fields into individual control lines.

Top module: `mc_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it falls, the micro-address is 0, the sequencer is stopped (running low) and the bad-address flag is low.
- R2: Writing an 80-bit row r puts micro-address 2r in bits 39:0 and micro-address 2r+1 in bits 79:40. Within a 40-bit word, fetch is bit 39, operand enables are 38:37, ALU control is 36:32, latch clear is 31:29, route select is 28:25, source select is 24:18, destination select is 17:11, memory control is 10:8, clock-off is bit 7 and next address is 6:0. The outputs show the fields of the word at the current micro-address.
- R3: A step taken on a word with fetch clear makes the word's next-address field the new micro-address.
- R4: A step taken on a word with fetch set makes the start-address input, sampled at that edge, the new micro-address.
- R5: While stopped with no step pulse, the micro-address and the presented word hold. Each step moves the micro-address exactly once.
- R6: A run pulse while stopped sets running high after the edge. One step then happens on every later edge, starting with the next one.
- R7: A stop pulse takes priority over every other command. No step happens on its edge, and running is low afterwards.
- R8: A step pulse while stopped performs exactly one step on its edge. While running, a step pulse has no effect beyond the normal run advance.
- R9: A next pulse while stopped sets running high and steps on each later edge up to and including the step on a word with fetch set, after which running is low.
- R10: A halt pulse while running keeps stepping until a step on a word with fetch set has been taken, then stops. A halt pulse while stopped is ignored.
- R11: A step taken while running on a word with clock-off set stops the sequencer after that step.
- R12: Micro-addresses 96 to 127 raise the bad-address flag and present an all-zero word, so the next step goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_run | input | 1 | Pulse: start continuous stepping |
| cmd_stop | input | 1 | Pulse: stop at once |
| cmd_step | input | 1 | Pulse: execute one word while stopped |
| cmd_next | input | 1 | Pulse: run to end of instruction while stopped |
| cmd_halt | input | 1 | Pulse: stop at end of the running instruction |
| start_addr | input | 7 | Start address of the next instruction |
| wr_en | input | 1 | Store row write enable |
| wr_row | input | 6 | Store row index |
| wr_data | input | 80 | Store row data (two words) |
| fetch_o | output | 1 | Fetch field of the current word |
| opnd_en_o | output | 2 | Operand enable field |
| alu_ctl_o | output | 5 | ALU control field |
| latch_clr_o | output | 3 | Latch clear field |
| route_o | output | 4 | Route select field |
| src_sel_o | output | 7 | Source register field |
| dst_sel_o | output | 7 | Destination register field |
| mem_ctl_o | output | 3 | Memory control field |
| clk_off_o | output | 1 | Clock-off field |
| next_addr_o | output | 7 | Next-address field |
| upc_o | output | 7 | Current micro-address |
| running_o | output | 1 | Sequencer is stepping on its own |
| bad_addr_o | output | 1 | Current micro-address is outside the store |

## Verification
Any fault in the alternating address registers or the read lookahead shows on upc_o and the field outputs in the cycle after the step that caused it. The word presented no longer matches the shadow word for that address, so a single stale or swapped register is visible immediately. A wrong run-control state shows up as running_o having the wrong value, or as a step taken or missed, on the very next edge. The vector walk covers each command in both the stopped and running states. It also crosses the edge of valid addresses.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;
  localparam int ADDR_W = 7;
  localparam int WORD_W = 40;

  typedef struct packed {
    logic       fetch;
    logic [1:0] opnd_en;
    logic [4:0] alu_ctl;
    logic [2:0] latch_clr;
    logic [3:0] route;
    logic [6:0] src_sel;
    logic [6:0] dst_sel;
    logic [2:0] mem_ctl;
    logic       clk_off;
    logic [ADDR_W-1:0] next_addr;
  } uword_t;

  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_RUN    = 2'd1,
    M_TO_END = 2'd2
  } run_mode_e;
endpackage

// File: rtl/mc_store.sv
module mc_store #(
  parameter int ROWS = 48,
  parameter int WW   = 40,
  localparam int RAW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [RAW-1:0]  wr_row,
  input  logic [2*WW-1:0] wr_data,
  input  logic [RAW-1:0]  rd_row,
  input  logic            rd_half,
  input  logic            rd_valid,
  output logic [WW-1:0]   rd_word,
  output logic            rd_bad
);
  logic [2*WW-1:0] mem [ROWS];
  logic [2*WW-1:0] row_q;
  logic            half_q;
  logic            valid_q;

  // synchronous write and read, read-first
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_row) < ROWS)) mem[wr_row] <= wr_data;
    row_q   <= mem[rd_row];
    half_q  <= rd_half;
    valid_q <= rd_valid;
  end

  // half select after the row register
  always_comb begin
    if (!valid_q)    rd_word = '0;
    else if (half_q) rd_word = row_q[2*WW-1:WW];
    else             rd_word = row_q[WW-1:0];
  end

  assign rd_bad = !valid_q;
endmodule

// File: rtl/mc_addr_pingpong.sv
module mc_addr_pingpong #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] cur_addr
);
  logic [1:0][AW-1:0] slot_q;
  logic               bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      bank_q <= 1'b0;
    end else if (advance) begin
      slot_q[~bank_q] <= load_addr;
      bank_q          <= ~bank_q;
    end
  end

  assign cur_addr = slot_q[bank_q];

  AST_PP_LOAD: assert property (@(posedge clk) disable iff (rst)
    advance |=> cur_addr == $past(load_addr)); // R3
  AST_PP_RETAIN: assert property (@(posedge clk) disable iff (rst)
    advance |=> slot_q[~bank_q] == $past(cur_addr)); // R5
endmodule

// File: rtl/mc_run_ctrl.sv
module mc_run_ctrl
  import mcseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_run,
  input  logic cmd_stop,
  input  logic cmd_step,
  input  logic cmd_next,
  input  logic cmd_halt,
  input  logic wd_fetch,
  input  logic wd_clk_off,
  output logic advance,
  output logic running
);
  run_mode_e mode_q, mode_d;
  logic      idle;

  always_comb begin
    idle    = (mode_q == M_IDLE);
    advance = !cmd_stop && (idle ? (cmd_step && !cmd_run && !cmd_next) : 1'b1);
    mode_d  = mode_q;
    if (cmd_stop) begin
      mode_d = M_IDLE;
    end else begin
      case (mode_q)
        M_IDLE: begin
          if (cmd_run)       mode_d = M_RUN;
          else if (cmd_next) mode_d = M_TO_END;
        end
        M_RUN: begin
          if (wd_clk_off || (cmd_halt && wd_fetch)) mode_d = M_IDLE;
          else if (cmd_halt)                        mode_d = M_TO_END;
        end
        M_TO_END: begin
          if (wd_clk_off || wd_fetch) mode_d = M_IDLE;
        end
        default: mode_d = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_IDLE;
    else     mode_q <= mode_d;
  end

  assign running = (mode_q != M_IDLE);

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
    cmd_stop |=> !running); // R7
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!running && cmd_halt && !cmd_run && !cmd_next) |=> !running); // R10
  AST_RUN_START: assert property (@(posedge clk) disable iff (rst)
    (!running && cmd_run && !cmd_stop) |=> running); // R6
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import mcseq_pkg::*;
#(
  parameter int WORDS = 96,
  localparam int ROWS = WORDS / 2,
  localparam int RAW  = $clog2(ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_run,
  input  logic                cmd_stop,
  input  logic                cmd_step,
  input  logic                cmd_next,
  input  logic                cmd_halt,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic                wr_en,
  input  logic [RAW-1:0]      wr_row,
  input  logic [2*WORD_W-1:0] wr_data,
  output logic                fetch_o,
  output logic [1:0]          opnd_en_o,
  output logic [4:0]          alu_ctl_o,
  output logic [2:0]          latch_clr_o,
  output logic [3:0]          route_o,
  output logic [6:0]          src_sel_o,
  output logic [6:0]          dst_sel_o,
  output logic [2:0]          mem_ctl_o,
  output logic                clk_off_o,
  output logic [ADDR_W-1:0]   next_addr_o,
  output logic [ADDR_W-1:0]   upc_o,
  output logic                running_o,
  output logic                bad_addr_o
);
  uword_t              word;
  logic [WORD_W-1:0]   word_bits;
  logic                advance;
  logic [ADDR_W-1:0]   step_target;
  logic [ADDR_W-1:0]   nxt_upc;
  logic                rd_valid;
  logic [RAW-1:0]      rd_row;

  assign word = uword_t'(word_bits);

  mc_run_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd_run    (cmd_run),
    .cmd_stop   (cmd_stop),
    .cmd_step   (cmd_step),
    .cmd_next   (cmd_next),
    .cmd_halt   (cmd_halt),
    .wd_fetch   (word.fetch),
    .wd_clk_off (word.clk_off),
    .advance    (advance),
    .running    (running_o)
  );

  always_comb begin
    step_target = word.fetch ? start_addr : word.next_addr;
    if (rst)          nxt_upc = '0;
    else if (advance) nxt_upc = step_target;
    else              nxt_upc = upc_o;
    rd_valid = (int'(nxt_upc) < WORDS);
    rd_row   = rd_valid ? RAW'(nxt_upc >> 1) : '0;
  end

  mc_addr_pingpong #(.AW(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .load_addr (step_target),
    .cur_addr  (upc_o)
  );

  mc_store #(.ROWS(ROWS), .WW(WORD_W)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .wr_data  (wr_data),
    .rd_row   (rd_row),
    .rd_half  (nxt_upc[0]),
    .rd_valid (rd_valid),
    .rd_word  (word_bits),
    .rd_bad   (bad_addr_o)
  );

  assign fetch_o     = word.fetch;
  assign opnd_en_o   = word.opnd_en;
  assign alu_ctl_o   = word.alu_ctl;
  assign latch_clr_o = word.latch_clr;
  assign route_o     = word.route;
  assign src_sel_o   = word.src_sel;
  assign dst_sel_o   = word.dst_sel;
  assign mem_ctl_o   = word.mem_ctl;
  assign clk_off_o   = word.clk_off;
  assign next_addr_o = word.next_addr;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!running_o && !cmd_step) |=> $stable(upc_o)); // R5
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!running_o && cmd_step && !cmd_run && !cmd_next && !cmd_stop)
      |=> upc_o == $past(fetch_o ? start_addr : next_addr_o)); // R8
  AST_CLKOFF_STOP: assert property (@(posedge clk) disable iff (rst)
    (running_o && clk_off_o && !cmd_stop) |=> !running_o); // R11
  AST_FETCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    (advance && fetch_o) |=> upc_o == $past(start_addr)); // R4
  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (rst)
    bad_addr_o == (int'(upc_o) >= WORDS)); // R12
  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    bad_addr_o |-> (word_bits == '0)); // R12
endmodule

// File: tb/sim_mc_sequencer.sv
`timescale 1ns/1ps
module sim_mc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_run = 0, cmd_stop = 0, cmd_step = 0, cmd_next = 0, cmd_halt = 0;
  logic [6:0]  start_addr = '0;
  logic        wr_en = 0;
  logic [5:0]  wr_row = '0;
  logic [79:0] wr_data = '0;
  logic        fetch_o, clk_off_o, running_o, bad_addr_o;
  logic [1:0]  opnd_en_o;
  logic [4:0]  alu_ctl_o;
  logic [2:0]  latch_clr_o, mem_ctl_o;
  logic [3:0]  route_o;
  logic [6:0]  src_sel_o, dst_sel_o, next_addr_o, upc_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [39:0] shw [96];

  always #2 clk = ~clk;

  mc_sequencer u0 (
    .clk(clk), .rst(rst), .cmd_run(cmd_run), .cmd_stop(cmd_stop), .cmd_step(cmd_step),
    .cmd_next(cmd_next), .cmd_halt(cmd_halt), .start_addr(start_addr),
    .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .fetch_o(fetch_o), .opnd_en_o(opnd_en_o), .alu_ctl_o(alu_ctl_o),
    .latch_clr_o(latch_clr_o), .route_o(route_o), .src_sel_o(src_sel_o),
    .dst_sel_o(dst_sel_o), .mem_ctl_o(mem_ctl_o), .clk_off_o(clk_off_o),
    .next_addr_o(next_addr_o), .upc_o(upc_o), .running_o(running_o),
    .bad_addr_o(bad_addr_o)
  );

  // layout per R2
  function automatic logic [39:0] mkw(input logic f, input logic [1:0] op, input logic [4:0] alu,
      input logic [2:0] lat, input logic [3:0] rt, input logic [6:0] src, input logic [6:0] dst,
      input logic [2:0] mem, input logic off, input logic [6:0] nx);
    return {f, op, alu, lat, rt, src, dst, mem, off, nx};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cmd(input logic [2:0] c);
    cmd_run  = (c == 3'd1);
    cmd_stop = (c == 3'd2);
    cmd_step = (c == 3'd3);
    cmd_next = (c == 3'd4);
    cmd_halt = (c == 3'd5);
  endtask

  function automatic logic [39:0] word_now();
    return {fetch_o, opnd_en_o, alu_ctl_o, latch_clr_o, route_o, src_sel_o,
            dst_sel_o, mem_ctl_o, clk_off_o, next_addr_o};
  endfunction

  // {req[3:0], cmd[2:0] (0 none,1 run,2 stop,3 step,4 next,5 halt), start[6:0], exp_upc[6:0], exp_run}
  localparam int NV = 27;
  localparam logic [21:0] VEC [NV] = '{
    {4'd8,  3'd3, 7'd5,  7'd1,   1'b0}, // R8 single step
    {4'd5,  3'd0, 7'd5,  7'd1,   1'b0}, // R5 hold
    {4'd3,  3'd3, 7'd5,  7'd2,   1'b0}, // R3 next field
    {4'd4,  3'd3, 7'd5,  7'd5,   1'b0}, // R4 fetch
    {4'd6,  3'd1, 7'd5,  7'd5,   1'b1}, // R6 run, no step yet
    {4'd6,  3'd0, 7'd5,  7'd6,   1'b1}, // R6
    {4'd4,  3'd0, 7'd7,  7'd7,   1'b1}, // R4 fetch while running
    {4'd6,  3'd0, 7'd7,  7'd8,   1'b1}, // R6
    {4'd8,  3'd3, 7'd7,  7'd9,   1'b1}, // R8 step while running
    {4'd11, 3'd0, 7'd7,  7'd12,  1'b0}, // R11 clock-off
    {4'd11, 3'd0, 7'd7,  7'd12,  1'b0}, // R11 stays stopped
    {4'd9,  3'd4, 7'd5,  7'd12,  1'b1}, // R9 next
    {4'd9,  3'd0, 7'd5,  7'd0,   1'b1}, // R9
    {4'd9,  3'd0, 7'd5,  7'd1,   1'b1}, // R9
    {4'd9,  3'd0, 7'd5,  7'd2,   1'b1}, // R9
    {4'd9,  3'd0, 7'd5,  7'd5,   1'b0}, // R9 stop after fetch
    {4'd10, 3'd5, 7'd5,  7'd5,   1'b0}, // R10 halt ignored
    {4'd6,  3'd1, 7'd5,  7'd5,   1'b1}, // R6
    {4'd10, 3'd5, 7'd5,  7'd6,   1'b1}, // R10 halt while running
    {4'd10, 3'd0, 7'd20, 7'd20,  1'b0}, // R10 stopped at end
    {4'd2,  3'd3, 7'd20, 7'd21,  1'b0}, // R2 odd half
    {4'd2,  3'd3, 7'd20, 7'd95,  1'b0}, // R2 last valid
    {4'd12, 3'd3, 7'd20, 7'd100, 1'b0}, // R12 invalid
    {4'd12, 3'd3, 7'd20, 7'd0,   1'b0}, // R12 zero word to 0
    {4'd6,  3'd1, 7'd20, 7'd0,   1'b1}, // R6
    {4'd7,  3'd2, 7'd20, 7'd0,   1'b0}, // R7 stop
    {4'd7,  3'd0, 7'd20, 7'd0,   1'b0}  // R7 stays
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 96; i++) shw[i] = '0;
    shw[0]  = mkw(0, 2'b00, 5'h00, 3'b000, 4'h3, 7'h11, 7'h00, 3'b000, 0, 7'd1);
    shw[1]  = mkw(0, 2'b01, 5'h00, 3'b000, 4'h0, 7'h00, 7'h00, 3'b000, 0, 7'd2);
    shw[2]  = mkw(1, 2'b11, 5'h00, 3'b000, 4'h0, 7'h00, 7'h00, 3'b000, 0, 7'd3);
    shw[5]  = mkw(0, 2'b00, 5'h1A, 3'b000, 4'h0, 7'h00, 7'h00, 3'b000, 0, 7'd6);
    shw[6]  = mkw(1, 2'b00, 5'h00, 3'b000, 4'h0, 7'h00, 7'h00, 3'b001, 0, 7'd0);
    shw[7]  = mkw(0, 2'b00, 5'h00, 3'b000, 4'h0, 7'h00, 7'h00, 3'b000, 0, 7'd8);
    shw[8]  = mkw(0, 2'b00, 5'h00, 3'b000, 4'h0, 7'h00, 7'h00, 3'b000, 0, 7'd9);
    shw[9]  = mkw(0, 2'b00, 5'h00, 3'b000, 4'h0, 7'h00, 7'h00, 3'b000, 1, 7'd12);
    shw[20] = mkw(0, 2'b10, 5'h15, 3'b101, 4'h9, 7'h2A, 7'h55, 3'b011, 0, 7'd21);
    shw[21] = mkw(0, 2'b01, 5'h0A, 3'b010, 4'h6, 7'h55, 7'h2A, 3'b100, 0, 7'd95);
    shw[95] = mkw(0, 2'b00, 5'h00, 3'b111, 4'h0, 7'h00, 7'h00, 3'b000, 0, 7'd100);

    repeat (3) @(negedge clk);
    chk("R1 upc in reset", 64'(upc_o), 64'd0);
    chk("R1 running in reset", 64'(running_o), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 upc after reset", 64'(upc_o), 64'd0);
    chk("R1 running after reset", 64'(running_o), 64'd0);
    chk("R1 bad flag after reset", 64'(bad_addr_o), 64'd0);

    for (int r = 0; r < 48; r++) begin
      wr_en = 1'b1; wr_row = 6'(r); wr_data = {shw[2*r+1], shw[2*r]};
      @(negedge clk);
    end
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 word at 0", 64'(word_now()), 64'(shw[0]));

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq;
      logic [6:0] eu;
      rq = VEC[i][21:18];
      eu = VEC[i][7:1];
      set_cmd(VEC[i][17:15]);
      start_addr = VEC[i][14:8];
      @(posedge clk);
      @(negedge clk);
      set_cmd(3'd0);
      chk($sformatf("R%0d upc row %0d", rq, i), 64'(upc_o), 64'(eu));
      chk($sformatf("R%0d running row %0d", rq, i), 64'(running_o), 64'(VEC[i][0]));
      if (eu < 7'd96) chk($sformatf("R2 word row %0d", i), 64'(word_now()), 64'(shw[eu]));
      else            chk($sformatf("R12 word row %0d", i), 64'(word_now()), 64'd0);
      chk($sformatf("R12 flag row %0d", i), 64'(bad_addr_o), 64'(eu >= 7'd96));
    end

    // R7: stop wins over a simultaneous step
    cmd_stop = 1'b1; cmd_step = 1'b1;
    @(posedge clk); @(negedge clk);
    set_cmd(3'd0);
    chk("R7 stop beats step", 64'(upc_o), 64'd0);

    // R6 then R1: reset while running
    set_cmd(3'd1);
    @(posedge clk); @(negedge clk);
    set_cmd(3'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 two run steps", 64'(upc_o), 64'd2);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 reset while running upc", 64'(upc_o), 64'd0);
    chk("R1 reset while running mode", 64'(running_o), 64'd0);
    @(negedge clk);
    chk("R5 hold after reset", 64'(upc_o), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule